// File: doc/BRIEF.md
# Program counter with a data-mapped low byte

This block holds the instruction address of a small 8-bit controller core. On every instruction cycle with the advance enable high, the whole counter moves forward by one. The increment carries across the full width, so running past the last word of a 256-word page leads into the next page.

The low eight bits of the counter also appear as a register in the core's special-function data space. A data-bus write to that register address puts the written byte into the low eight bits and leaves the page bits as they were. This gives a computed jump that stays inside the current page. The jump costs one dummy cycle. During that cycle the counter holds the target, and a bubble output tells the core to discard whatever it fetched. A read path returns the current low byte to the data bus.

Top module: `pgm_counter`

## Requirements
- R1: While the active-low reset is asserted the whole address is 0 and the bubble output is 0; both keep those values at the first clock edge after reset is released, unless a low-byte write or an advance takes place at that edge.
- R2: Outside a dummy cycle and with no low-byte write, a clock edge with the advance enable high adds one to the address, and a clock edge with it low leaves the address unchanged.
- R3: The advance uses the full counter width. An address whose low byte is 0xFF goes to the first word of the next page. The all-ones address goes to 0.
- R4: A write strobe whose address equals the parameter LOW_REG_ADDR (default 2) loads the write data into address bits [7:0] at that clock edge and keeps bits [PC_W-1:8] unchanged.
- R5: A write strobe at any other address has no effect on the address or on the bubble output.
- R6: After a low-byte write the bubble output is 1 for exactly one cycle. During that cycle the address holds the jump target even when the advance enable is high.
- R7: The low-byte readback always equals address bits [7:0].
- R8: When a low-byte write and the advance enable occur together, the write wins and the address becomes the written target, not the target plus one.
- R9: A low-byte write during the dummy cycle loads its new target and starts a fresh one-cycle bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance the counter by one this cycle |
| wr_en | input | 1 | Data-bus write strobe |
| wr_addr | input | ADDR_W | Data-bus write address |
| wr_data | input | 8 | Data-bus write data |
| pc_addr | output | PC_W | Current program address |
| low_rd | output | 8 | Readback of the address low byte |
| bubble | output | 1 | High during the dummy cycle after a low-byte jump |

## Verification
The assertions assume that the write strobe, address, data and advance enable are steady and known at each rising edge. They also assume that reset is only ever released with the counter in its cleared state. They accept any mix of writes and advances in any cycle, including writes in the dummy cycle. The bench changes every input only at the falling edge and keeps all values two-state. Its random stimulus mixes writes to the mapped address, writes to other addresses and advance patterns, so that the dummy cycle, write priority and write-during-bubble cases all occur.

// File: rtl/pgm_counter_pkg.sv
package pgm_counter_pkg;

   localparam int unsigned PAGE_BITS = 8;

   typedef enum logic [1:0] {
      NX_HOLD = 2'd0,
      NX_STEP = 2'd1,
      NX_LOAD = 2'd2
   } nx_sel_e;

endpackage

// File: rtl/pc_addr_match.sv
module pc_addr_match #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned LOW_REG_ADDR = 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(LOW_REG_ADDR);

   always_comb begin
      hit = wr_en && (wr_addr == MATCH);
   end
endmodule

// File: rtl/pc_sel.sv
module pc_sel
   import pgm_counter_pkg::*;
(
   input  logic    hit,
   input  logic    in_bubble,
   input  logic    step_en,
   output nx_sel_e sel,
   output logic    bubble_nx
);
   always_comb begin
      if (hit) begin
         sel       = NX_LOAD;
         bubble_nx = 1'b1;
      end else if (in_bubble) begin
         sel       = NX_HOLD;
         bubble_nx = 1'b0;
      end else if (step_en) begin
         sel       = NX_STEP;
         bubble_nx = 1'b0;
      end else begin
         sel       = NX_HOLD;
         bubble_nx = 1'b0;
      end
   end
endmodule

// File: rtl/pc_next_val.sv
module pc_next_val
   import pgm_counter_pkg::*;
#(
   parameter int unsigned PC_W = 12
) (
   input  logic [PC_W-1:0]      pc,
   input  logic [PAGE_BITS-1:0] wr_data,
   input  nx_sel_e              sel,
   output logic [PC_W-1:0]      pc_nx
);
   logic [PC_W-1:0] target;

   generate
      if (PC_W == PAGE_BITS) begin : g_single_page
         always_comb target = wr_data;
      end else begin : g_paged
         always_comb target = {pc[PC_W-1:PAGE_BITS], wr_data};
      end
   endgenerate

   always_comb begin
      unique case (sel)
         NX_LOAD: pc_nx = target;
         NX_STEP: pc_nx = pc + PC_W'(1);
         default: pc_nx = pc;
      endcase
   end
endmodule

// File: rtl/pgm_counter.sv
module pgm_counter
   import pgm_counter_pkg::*;
#(
   parameter int unsigned PC_W         = 12,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned LOW_REG_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic [PC_W-1:0]   pc_addr,
   output logic [7:0]        low_rd,
   output logic              bubble
);
   generate
      if (PC_W < PAGE_BITS || PC_W > 24) begin : g_bad_pc_w
         $error("pgm_counter: PC_W must lie in 8..24");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("pgm_counter: ADDR_W must lie in 1..16");
      end
      if (LOW_REG_ADDR >= (1 << ADDR_W)) begin : g_bad_low_addr
         $error("pgm_counter: LOW_REG_ADDR does not fit in ADDR_W");
      end
   endgenerate

   logic            hit;
   logic            bubble_nx;
   nx_sel_e         sel;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_nx;
   logic            bub_q;

   pc_addr_match #(.ADDR_W(ADDR_W), .LOW_REG_ADDR(LOW_REG_ADDR)) u_match (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .hit     (hit)
   );

   pc_sel u_sel (
      .hit       (hit),
      .in_bubble (bub_q),
      .step_en   (step_en),
      .sel       (sel),
      .bubble_nx (bubble_nx)
   );

   pc_next_val #(.PC_W(PC_W)) u_next (
      .pc      (pc_q),
      .wr_data (wr_data),
      .sel     (sel),
      .pc_nx   (pc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         bub_q <= 1'b0;
      end else begin
         pc_q  <= pc_nx;
         bub_q <= bubble_nx;
      end
   end

   assign pc_addr = pc_q;
   assign low_rd  = pc_q[7:0];
   assign bubble  = bub_q;

   // R1: reset state
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (pc_q == '0 && !bub_q));

   // R2: plain advance
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !bub_q && step_en) |=> (pc_q == $past(pc_q) + PC_W'(1)));

   // R2: idle hold
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !bub_q && !step_en) |=> $stable(pc_q));

   // R4, R8: low byte loaded, page kept
   p_load_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (pc_q[7:0] == $past(wr_data)));

   p_page_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ((pc_q >> PAGE_BITS) == ($past(pc_q) >> PAGE_BITS)));

   // R6, R9: bubble follows each low-byte write
   p_bubble_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> bub_q);

   p_bubble_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bub_q && !hit) |=> !bub_q);

   p_bubble_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bub_q && !hit) |=> $stable(pc_q));

   // R7: readback mirrors address
   always_comb begin
      a_low_mirror_r7: assert (low_rd == pc_addr[7:0]);
   end
endmodule

// File: tb/sim_pgm_counter.sv
`timescale 1ns/1ps
module sim_pgm_counter;
   localparam int unsigned PC_W = 12;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned LOW_A = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              step_en = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic [PC_W-1:0]   pc_addr;
   logic [7:0]        low_rd;
   logic              bubble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [PC_W-1:0] exp_pc = '0;
   logic            exp_bub = 1'b0;

   always #2 clk = ~clk;

   pgm_counter #(.PC_W(PC_W), .ADDR_W(ADDR_W), .LOW_REG_ADDR(LOW_A)) u0 (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pc_addr(pc_addr),
      .low_rd(low_rd), .bubble(bubble)
   );

   function automatic logic [PC_W-1:0] next_pc(logic [PC_W-1:0] pc, logic bub,
      logic st, logic we, logic [ADDR_W-1:0] a, logic [7:0] d);
      if (we && a == ADDR_W'(LOW_A)) return {pc[PC_W-1:8], d};
      if (bub) return pc;
      if (st) return pc + PC_W'(1);
      return pc;
   endfunction

   function automatic logic next_bub(logic we, logic [ADDR_W-1:0] a);
      return we && a == ADDR_W'(LOW_A);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, 32'(pc_addr), 32'(exp_pc));
      chk(req, 32'(bubble), 32'(exp_bub));
      chk("R7", 32'(low_rd), 32'(exp_pc[7:0]));
   endtask

   // drive at negedge, apply at posedge, sample at following negedge
   task automatic cyc(logic st, logic we, logic [ADDR_W-1:0] a, logic [7:0] d,
                      string req);
      step_en = st; wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      exp_pc  = next_pc(exp_pc, exp_bub, st, we, a, d);
      exp_bub = next_bub(we, a);
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] ra;
      void'($urandom(32'd20240611));
      step_en = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, '0, 8'h00, "R1");
      cyc(1'b1, 1'b0, '0, 8'h00, "R2");
      cyc(1'b1, 1'b0, '0, 8'h00, "R2");
      cyc(1'b0, 1'b0, '0, 8'h00, "R2");
      // jump near the page end, bubble holds target
      cyc(1'b0, 1'b1, ADDR_W'(LOW_A), 8'hFE, "R4");
      cyc(1'b1, 1'b0, '0, 8'h00, "R6");
      cyc(1'b1, 1'b0, '0, 8'h00, "R6");
      cyc(1'b1, 1'b0, '0, 8'h00, "R3");
      chk("R3", 32'(pc_addr), 32'h100);
      // page kept on a jump
      cyc(1'b0, 1'b1, ADDR_W'(LOW_A), 8'h34, "R4");
      chk("R4", 32'(pc_addr), 32'h134);
      cyc(1'b0, 1'b0, '0, 8'h00, "R6");
      // other address ignored
      cyc(1'b0, 1'b1, ADDR_W'(LOW_A + 1), 8'h99, "R5");
      cyc(1'b1, 1'b1, ADDR_W'(0), 8'h55, "R5");
      chk("R5", 32'(pc_addr), 32'h135);
      // write wins over advance
      cyc(1'b1, 1'b1, ADDR_W'(LOW_A), 8'h80, "R8");
      chk("R8", 32'(pc_addr), 32'h180);
      // write in the dummy cycle
      cyc(1'b1, 1'b1, ADDR_W'(LOW_A), 8'h10, "R9");
      chk("R9", 32'(bubble), 32'h1);
      cyc(1'b1, 1'b0, '0, 8'h00, "R9");
      chk("R9", 32'(pc_addr), 32'h110);
      cyc(1'b1, 1'b0, '0, 8'h00, "R2");
      // run to the all-ones address and wrap
      for (int i = 0; i < 5000 && exp_pc != '1; i++) cyc(1'b1, 1'b0, '0, 8'h00, "R3");
      cyc(1'b1, 1'b0, '0, 8'h00, "R3");
      chk("R3", 32'(pc_addr), 32'h0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         ra = ($urandom % 3 == 0) ? ADDR_W'(LOW_A) : ADDR_W'($urandom % 8);
         cyc(1'($urandom % 4 != 0), 1'($urandom % 5 == 0), ra,
             8'($urandom), "R4 R5 R6 R9 mix");
      end
      // reset in the middle of activity
      rst_n = 1'b0;
      exp_pc = '0; exp_bub = 1'b0;
      @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule